// File: doc/BRIEF.md
# LCD Scanline Dot Sequencer

This block produces the dot-by-dot timing of a 160x144 liquid-crystal display controller. It advances once per dot clock and reports several things: the current line number, a 2-bit phase (mode) field, and the line value used for line-compare logic together with a valid flag. It also drives four independent blocking flags, which gate CPU reads and writes of the sprite-attribute memory and of the video memory.

Three event outputs come from the same sequence: a one-cycle horizontal-blank pulse that starts a DMA transfer, a one-cycle vertical-blank interrupt request, and a pixel-column strobe carrying the on-screen x coordinate. The pixel strobe is a plain qualifier with no ready input. The display timing is fixed, so no back-pressure is possible, and a consumer must accept every strobed column.

The block has two inputs. The display-enable bit restarts the sequence whenever it rises. The fine horizontal scroll value (0..7) is sampled once per line at the start of pixel transfer, and the sampled value stretches that line's transfer phase. The first line after enable is shorter and follows its own phase order. The last line of the frame makes the reported line number and the compare value diverge for a short time.

Top module: `lcd_dot_sequencer`

## Requirements
- R1: A normal line lasts 456 dots and a frame has 154 lines numbered 0..153. `line_num` equals the line index, except in the final line as R10 describes.
- R2: Mode encoding is 0 = horizontal blank, 1 = vertical blank, 2 = sprite search, 3 = pixel transfer. On a normal visible line (0..143), mode is 0 for dots 0..3, 2 for dots 4..83, 3 for dots 84 to 255+F, and 0 for the rest of the line.
- R3: F is the `fine_scroll` value sampled at the dot where transfer begins. Changes to `fine_scroll` at any other dot have no effect on that line, so the transfer phase lasts exactly 172+F dots.
- R4: On a normal visible line, sprite reads are blocked from dot 0 up to the end of transfer. Sprite writes are blocked for dots 4..79 and again from dot 84 to the end of transfer. Video reads are blocked from dot 80 to the end of transfer, and video writes from dot 84 to the end of transfer. All four flags are clear in horizontal blank and on lines 144..153.
- R5: `cmp_valid` is 0 for dots 0..3 of lines 1..152. Otherwise it is 1 and `cmp_line` equals the line index. Whenever `cmp_valid` is 0, `cmp_line` reads 0.
- R6: `hblank_dma` pulses for exactly one cycle, on the first horizontal-blank dot after transfer (dot 256+F) of each normal visible line, and at no other time.
- R7: During transfer, a position counter runs over dots 84..250 and x = (dot - 84) - F. `pix_strobe` is 1 only when 0 <= x < 160, giving exactly 160 strobes per normal visible line. `pix_x` carries x while strobed and 0 otherwise.
- R8: The first line after enable lasts 448 dots. It reports mode 0 with no blocking for dots 0..75 and mode 3 with all four flags set for dots 76 to 249+F, where F is sampled at dot 76. It then reports mode 0 with no blocking. It has no pixel strobes and no DMA pulse, and it counts as line 0.
- R9: On line 144, mode stays 0 for dots 0..3 and becomes 1 at dot 4, where `vblank_irq` pulses for one cycle. Lines 145..153 report mode 1 throughout, and exactly one request is made per frame.
- R10: On line 153, `line_num` reads 153 for dots 0..3 and 0 from dot 4 onward. Over the same line, the compare is invalid for dots 0..3, then 153 for dots 4..7, then invalid for dots 8..11, then 0 for the rest of the line.
- R11: While the display is disabled, and during reset, the outputs take a fixed state. `line_num` = 0, mode = 0, `cmp_line` = 0 with `cmp_valid` = 1, all blocking flags are clear, and no pulse or strobe occurs. A horizontal-blank DMA pulse that was about to fire is dropped.
- R12: When enable is sampled high after being low, the following cycle shows dot 0 of the first-line sequence of R8. All outputs come from registers and change only on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en | input | 1 | Display enable bit from the control register |
| fine_scroll | input | FINE_W (3) | Fine horizontal scroll (scroll x modulo 8) |
| line_num | output | LINE_W (8) | Reported line number |
| mode | output | 2 | Phase field (0 hblank, 1 vblank, 2 search, 3 transfer) |
| cmp_line | output | LINE_W (8) | Line value presented to line-compare logic |
| cmp_valid | output | 1 | Compare value is meaningful |
| spr_rd_blk | output | 1 | CPU reads of sprite-attribute memory blocked |
| spr_wr_blk | output | 1 | CPU writes of sprite-attribute memory blocked |
| vid_rd_blk | output | 1 | CPU reads of video memory blocked |
| vid_wr_blk | output | 1 | CPU writes of video memory blocked |
| hblank_dma | output | 1 | One-cycle horizontal-blank DMA start pulse |
| vblank_irq | output | 1 | One-cycle vertical-blank interrupt request |
| pix_strobe | output | 1 | Pixel column valid this cycle |
| pix_x | output | X_W (8) | Screen x of the strobed column |

## Verification
The assertions take for granted that `disp_en` and `fine_scroll` are synchronous to `clk` and that reset is applied before the first enable. Some rules bind only in a line whose scroll sample is stable, such as the mode-3 length and the DMA pulse following mode 3. The stimulus changes `fine_scroll` on every falling edge from a shift-register sequence, so each line samples a different value and every value 0..7 shows up across a frame. Enable is dropped in the middle of a transfer phase and raised again, which exercises the forced-off state and the restart into the short first line.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    MD_HBLANK = 2'd0,
    MD_VBLANK = 2'd1,
    MD_SEARCH = 2'd2,
    MD_XFER   = 2'd3
  } lcd_mode_e;

  typedef struct packed {
    logic spr_rd;
    logic spr_wr;
    logic vid_rd;
    logic vid_wr;
  } blk_t;

endpackage

// File: rtl/lcd_seq_counter.sv
module lcd_seq_counter #(
  parameter int LINE_DOTS        = 456,
  parameter int FIRST_LINE_DOTS  = 448,
  parameter int FRAME_LINES      = 154,
  parameter int ACTIVE_LINES     = 144,
  parameter int XFER_START       = 84,
  parameter int FIRST_XFER_START = 76,
  parameter int FINE_W           = 3,
  parameter int DOT_W            = $clog2(LINE_DOTS),
  parameter int LINE_W           = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FINE_W-1:0] fine_scroll,
  output logic              nxt_on,
  output logic              nxt_first,
  output logic [DOT_W-1:0]  nxt_dot,
  output logic [LINE_W-1:0] nxt_line,
  output logic [FINE_W-1:0] nxt_fs
);

  localparam logic [DOT_W-1:0]  D_LAST  = DOT_W'(LINE_DOTS - 1);
  localparam logic [DOT_W-1:0]  D_FLAST = DOT_W'(FIRST_LINE_DOTS - 1);
  localparam logic [DOT_W-1:0]  D_XS    = DOT_W'(XFER_START);
  localparam logic [DOT_W-1:0]  D_FXS   = DOT_W'(FIRST_XFER_START);
  localparam logic [LINE_W-1:0] L_LAST  = LINE_W'(FRAME_LINES - 1);
  localparam logic [LINE_W-1:0] L_ACT   = LINE_W'(ACTIVE_LINES);

  logic              on_q, first_q;
  logic [DOT_W-1:0]  dot_q;
  logic [LINE_W-1:0] line_q;
  logic [FINE_W-1:0] fs_q;
  logic              latch;

  // Next-state of the dot/line position; decode downstream works on these.
  always_comb begin
    nxt_on    = on_q;
    nxt_first = first_q;
    nxt_dot   = dot_q;
    nxt_line  = line_q;
    if (!en) begin
      nxt_on    = 1'b0;
      nxt_first = 1'b1;
      nxt_dot   = '0;
      nxt_line  = '0;
    end else if (!on_q) begin
      nxt_on    = 1'b1;
      nxt_first = 1'b1;
      nxt_dot   = '0;
      nxt_line  = '0;
    end else if (dot_q == (first_q ? D_FLAST : D_LAST)) begin
      nxt_dot   = '0;
      nxt_first = 1'b0;
      nxt_line  = (line_q == L_LAST) ? '0 : line_q + 1'b1;
    end else begin
      nxt_dot   = dot_q + 1'b1;
    end
  end

  // Scroll is sampled once per visible line, on the dot transfer begins.
  assign latch  = nxt_on && (nxt_line < L_ACT) &&
                  (nxt_dot == (nxt_first ? D_FXS : D_XS));
  assign nxt_fs = latch ? fine_scroll : fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      first_q <= 1'b1;
      dot_q   <= '0;
      line_q  <= '0;
      fs_q    <= '0;
    end else begin
      on_q    <= nxt_on;
      first_q <= nxt_first;
      dot_q   <= nxt_dot;
      line_q  <= nxt_line;
      fs_q    <= nxt_fs;
    end
  end

  p_dot_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (dot_q <= D_LAST));

  p_line_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    on_q |-> (line_q <= L_LAST));

  p_first_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && first_q) |-> (dot_q <= D_FLAST && line_q == '0));

  p_scroll_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_q) |-> (dot_q == D_XS || dot_q == D_FXS));

  p_off_parks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!on_q && dot_q == '0 && line_q == '0));

endmodule

// File: rtl/lcd_seq_phase.sv
module lcd_seq_phase
  import lcd_seq_pkg::*;
#(
  parameter int SEARCH_DOTS      = 80,
  parameter int XFER_DOTS        = 172,
  parameter int FIRST_XFER_DOTS  = 174,
  parameter int LEAD             = 4,
  parameter int ACTIVE_LINES     = 144,
  parameter int FRAME_LINES      = 154,
  parameter int FINE_W           = 3,
  parameter int DOT_W            = 9,
  parameter int LINE_W           = 8
) (
  input  logic              on,
  input  logic              first,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic [FINE_W-1:0] fs,
  output lcd_mode_e         mode,
  output blk_t              blk,
  output logic [LINE_W-1:0] ly,
  output logic [LINE_W-1:0] cmp,
  output logic              cmp_ok,
  output logic              hdma,
  output logic              vbl
);

  localparam logic [DOT_W-1:0]  D_STEP  = DOT_W'(LEAD);
  localparam logic [DOT_W-1:0]  D_STEP2 = DOT_W'(2 * LEAD);
  localparam logic [DOT_W-1:0]  D_STEP3 = DOT_W'(3 * LEAD);
  localparam logic [DOT_W-1:0]  D_SRCH  = DOT_W'(SEARCH_DOTS);
  localparam logic [DOT_W-1:0]  D_XS    = DOT_W'(SEARCH_DOTS + LEAD);
  localparam logic [DOT_W-1:0]  D_FXS   = DOT_W'(SEARCH_DOTS - LEAD);
  localparam logic [DOT_W-1:0]  D_XLEN  = DOT_W'(XFER_DOTS);
  localparam logic [DOT_W-1:0]  D_FXLEN = DOT_W'(FIRST_XFER_DOTS);
  localparam logic [LINE_W-1:0] L_ACT   = LINE_W'(ACTIVE_LINES);
  localparam logic [LINE_W-1:0] L_LAST  = LINE_W'(FRAME_LINES - 1);

  logic [DOT_W-1:0] fs_ext, xfer_end, first_end;
  logic             in_xfer, in_first_xfer;

  assign fs_ext        = DOT_W'(fs);
  assign xfer_end      = D_XS + D_XLEN + fs_ext;
  assign first_end     = D_FXS + D_FXLEN + fs_ext;
  assign in_xfer       = (dot >= D_XS) && (dot < xfer_end);
  assign in_first_xfer = (dot >= D_FXS) && (dot < first_end);

  always_comb begin
    mode   = MD_HBLANK;
    blk    = '0;
    ly     = line;
    cmp    = line;
    cmp_ok = 1'b1;
    hdma   = 1'b0;
    vbl    = 1'b0;
    if (!on) begin
      ly  = '0;
      cmp = '0;
    end else if (first) begin
      // shortened opening line: idle, then fully blocked transfer
      if (in_first_xfer) begin
        mode = MD_XFER;
        blk  = '1;
      end
    end else if (line < L_ACT) begin
      if (in_xfer)
        mode = MD_XFER;
      else if (dot >= D_STEP && dot < D_XS)
        mode = MD_SEARCH;
      blk.spr_rd = dot < xfer_end;
      blk.spr_wr = in_xfer || (dot >= D_STEP && dot < D_SRCH);
      blk.vid_rd = (dot >= D_SRCH) && (dot < xfer_end);
      blk.vid_wr = in_xfer;
      cmp_ok     = !(dot < D_STEP && line != '0);
      hdma       = dot == xfer_end;
    end else if (line != L_LAST) begin
      mode   = (line == L_ACT && dot < D_STEP) ? MD_HBLANK : MD_VBLANK;
      cmp_ok = dot >= D_STEP;
      vbl    = (line == L_ACT) && (dot == D_STEP);
    end else begin
      // final line: reported line wraps early, compare lags behind it
      mode = MD_VBLANK;
      if (dot >= D_STEP)
        ly = '0;
      if (dot < D_STEP)
        cmp_ok = 1'b0;
      else if (dot < D_STEP2)
        cmp = L_LAST;
      else if (dot < D_STEP3)
        cmp_ok = 1'b0;
      else
        cmp = '0;
    end
    if (!cmp_ok)
      cmp = '0;
  end

endmodule

// File: rtl/lcd_seq_pixel.sv
module lcd_seq_pixel #(
  parameter int XFER_START   = 84,
  parameter int PIX_STEPS    = 167,
  parameter int H_PIXELS     = 160,
  parameter int ACTIVE_LINES = 144,
  parameter int FINE_W       = 3,
  parameter int DOT_W        = 9,
  parameter int LINE_W       = 8,
  parameter int X_W          = 8
) (
  input  logic              on,
  input  logic              first,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic [FINE_W-1:0] fs,
  output logic              strobe,
  output logic [X_W-1:0]    x
);

  localparam logic [DOT_W-1:0]  D_XS    = DOT_W'(XFER_START);
  localparam logic [DOT_W-1:0]  D_STEPS = DOT_W'(PIX_STEPS);
  localparam logic [DOT_W-1:0]  D_HPIX  = DOT_W'(H_PIXELS);
  localparam logic [LINE_W-1:0] L_ACT   = LINE_W'(ACTIVE_LINES);

  logic [DOT_W-1:0] pos, fs_ext, xs;
  logic             in_run;

  assign fs_ext = DOT_W'(fs);
  assign pos    = dot - D_XS;
  assign in_run = on && !first && (line < L_ACT) && (dot >= D_XS) && (pos < D_STEPS);
  assign xs     = pos - fs_ext;
  assign strobe = in_run && (pos >= fs_ext) && (xs < D_HPIX);
  assign x      = strobe ? xs[X_W-1:0] : '0;

endmodule

// File: rtl/lcd_dot_sequencer.sv
module lcd_dot_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int LINE_DOTS        = 456,
  parameter int SEARCH_DOTS      = 80,
  parameter int XFER_DOTS        = 172,
  parameter int ACTIVE_LINES     = 144,
  parameter int FRAME_LINES      = 154,
  parameter int H_PIXELS         = 160,
  parameter int FINE_W           = 3,
  parameter int LEAD             = 4,
  parameter int FIRST_XFER_EXTRA = 2,
  parameter int DOT_W            = $clog2(LINE_DOTS),
  parameter int LINE_W           = $clog2(FRAME_LINES),
  parameter int X_W              = $clog2(H_PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic [FINE_W-1:0] fine_scroll,
  output logic [LINE_W-1:0] line_num,
  output logic [1:0]        mode,
  output logic [LINE_W-1:0] cmp_line,
  output logic              cmp_valid,
  output logic              spr_rd_blk,
  output logic              spr_wr_blk,
  output logic              vid_rd_blk,
  output logic              vid_wr_blk,
  output logic              hblank_dma,
  output logic              vblank_irq,
  output logic              pix_strobe,
  output logic [X_W-1:0]    pix_x
);

  localparam int FIRST_LINE_DOTS  = LINE_DOTS - 2 * LEAD;
  localparam int XFER_START       = SEARCH_DOTS + LEAD;
  localparam int FIRST_XFER_START = SEARCH_DOTS - LEAD;
  localparam int FIRST_XFER_DOTS  = XFER_DOTS + FIRST_XFER_EXTRA;
  localparam int PIX_STEPS        = H_PIXELS + (2 ** FINE_W) - 1;
  localparam logic [LINE_W-1:0] L_ACT = LINE_W'(ACTIVE_LINES);
  localparam logic [X_W-1:0]    X_LIM = X_W'(H_PIXELS);

  logic              n_on, n_first;
  logic [DOT_W-1:0]  n_dot;
  logic [LINE_W-1:0] n_line;
  logic [FINE_W-1:0] n_fs;

  lcd_mode_e         d_mode;
  blk_t              d_blk;
  logic [LINE_W-1:0] d_ly, d_cmp;
  logic              d_cmp_ok, d_hdma, d_vbl, d_strobe;
  logic [X_W-1:0]    d_x;

  lcd_seq_counter #(
    .LINE_DOTS(LINE_DOTS), .FIRST_LINE_DOTS(FIRST_LINE_DOTS),
    .FRAME_LINES(FRAME_LINES), .ACTIVE_LINES(ACTIVE_LINES),
    .XFER_START(XFER_START), .FIRST_XFER_START(FIRST_XFER_START),
    .FINE_W(FINE_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .en(disp_en), .fine_scroll(fine_scroll),
    .nxt_on(n_on), .nxt_first(n_first), .nxt_dot(n_dot),
    .nxt_line(n_line), .nxt_fs(n_fs)
  );

  lcd_seq_phase #(
    .SEARCH_DOTS(SEARCH_DOTS), .XFER_DOTS(XFER_DOTS),
    .FIRST_XFER_DOTS(FIRST_XFER_DOTS), .LEAD(LEAD),
    .ACTIVE_LINES(ACTIVE_LINES), .FRAME_LINES(FRAME_LINES),
    .FINE_W(FINE_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_phase (
    .on(n_on), .first(n_first), .dot(n_dot), .line(n_line), .fs(n_fs),
    .mode(d_mode), .blk(d_blk), .ly(d_ly), .cmp(d_cmp), .cmp_ok(d_cmp_ok),
    .hdma(d_hdma), .vbl(d_vbl)
  );

  lcd_seq_pixel #(
    .XFER_START(XFER_START), .PIX_STEPS(PIX_STEPS), .H_PIXELS(H_PIXELS),
    .ACTIVE_LINES(ACTIVE_LINES), .FINE_W(FINE_W), .DOT_W(DOT_W),
    .LINE_W(LINE_W), .X_W(X_W)
  ) u_pixel (
    .on(n_on), .first(n_first), .dot(n_dot), .line(n_line), .fs(n_fs),
    .strobe(d_strobe), .x(d_x)
  );

  lcd_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_num   <= '0;
      mode_q     <= MD_HBLANK;
      cmp_line   <= '0;
      cmp_valid  <= 1'b1;
      spr_rd_blk <= 1'b0;
      spr_wr_blk <= 1'b0;
      vid_rd_blk <= 1'b0;
      vid_wr_blk <= 1'b0;
      hblank_dma <= 1'b0;
      vblank_irq <= 1'b0;
      pix_strobe <= 1'b0;
      pix_x      <= '0;
    end else begin
      line_num   <= d_ly;
      mode_q     <= d_mode;
      cmp_line   <= d_cmp;
      cmp_valid  <= d_cmp_ok;
      spr_rd_blk <= d_blk.spr_rd;
      spr_wr_blk <= d_blk.spr_wr;
      vid_rd_blk <= d_blk.vid_rd;
      vid_wr_blk <= d_blk.vid_wr;
      hblank_dma <= d_hdma;
      vblank_irq <= d_vbl;
      pix_strobe <= d_strobe;
      pix_x      <= d_x;
    end
  end

  assign mode = mode_q;

  p_strobe_in_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> (mode == 2'd3 && pix_x < X_LIM));

  p_dma_ends_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_dma |-> (mode == 2'd0 && $past(mode) == 2'd3));

  p_vblank_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (mode == 2'd1 && line_num == L_ACT && $past(mode) == 2'd0));

  p_vid_write_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vid_wr_blk |-> (vid_rd_blk && spr_rd_blk && spr_wr_blk));

  p_search_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> spr_rd_blk);

  p_off_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (line_num == '0 && mode == 2'd0 && cmp_valid && cmp_line == '0 &&
                  !spr_rd_blk && !spr_wr_blk && !vid_rd_blk && !vid_wr_blk &&
                  !hblank_dma && !pix_strobe));

endmodule

// File: tb/test_lcd_dot_sequencer.sv
`timescale 1ns/1ps
module test_lcd_dot_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_en = 1'b0;
  logic [2:0] fine_scroll = 3'd0;
  logic [7:0] line_num, cmp_line, pix_x;
  logic [1:0] mode;
  logic       cmp_valid, spr_rd_blk, spr_wr_blk, vid_rd_blk, vid_wr_blk;
  logic       hblank_dma, vblank_irq, pix_strobe;

  always #2.5 clk = ~clk;

  lcd_dot_sequencer i_lcd_dot_sequencer (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .fine_scroll(fine_scroll),
    .line_num(line_num), .mode(mode), .cmp_line(cmp_line), .cmp_valid(cmp_valid),
    .spr_rd_blk(spr_rd_blk), .spr_wr_blk(spr_wr_blk), .vid_rd_blk(vid_rd_blk),
    .vid_wr_blk(vid_wr_blk), .hblank_dma(hblank_dma), .vblank_irq(vblank_irq),
    .pix_strobe(pix_strobe), .pix_x(pix_x)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  // reference position, built from the requirement text
  bit m_on = 0, m_first = 1;
  int m_dot = 0, m_line = 0, m_fs = 0;
  logic [15:0] lfsr = 16'hACE1;

  int e_line, e_mode, e_cmp, e_ps, e_px;
  bit e_ok, e_hd, e_vb;
  logic [3:0] e_blk;

  int cnt_strobe = 0, cnt_xfer = 0, cnt_hd = 0, cnt_vb = 0;
  bit saw_first = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s (line %0d dot %0d) actual=%0d expected=%0d",
               req, what, m_line, m_dot, act, exp);
    end
  endtask

  function automatic string tag(input string dflt);
    if (!m_on) return "R11";
    if (m_first) return "R8";
    if (m_line == 153) return "R10";
    return dflt;
  endfunction

  task automatic model_step();
    if (!rst_n || !disp_en) begin
      m_on = 0; m_first = 1; m_dot = 0; m_line = 0;
      if (!rst_n) m_fs = 0;
    end else if (!m_on) begin
      m_on = 1; m_first = 1; m_dot = 0; m_line = 0;
    end else if (m_dot == (m_first ? 447 : 455)) begin
      m_dot = 0; m_first = 0;
      m_line = (m_line == 153) ? 0 : m_line + 1;
    end else begin
      m_dot++;
    end
    if (m_on && m_line < 144 && m_dot == (m_first ? 76 : 84))
      m_fs = int'(fine_scroll);
  endtask

  task automatic calc();
    int d, f, end3;
    d = m_dot; f = m_fs;
    e_line = m_line; e_mode = 0; e_cmp = m_line; e_ok = 1;
    e_blk = 4'b0000; e_hd = 0; e_vb = 0; e_ps = 0; e_px = 0;
    if (!m_on) begin
      e_line = 0; e_cmp = 0;
    end else if (m_first) begin
      if (d >= 76 && d < 250 + f) begin e_mode = 3; e_blk = 4'b1111; end
    end else if (m_line < 144) begin
      end3 = 256 + f;
      if (d < 4) begin e_mode = 0; e_ok = (m_line == 0); end
      else if (d < 84) e_mode = 2;
      else if (d < end3) e_mode = 3;
      e_blk[3] = d < end3;
      e_blk[2] = (d >= 4 && d < 80) || (d >= 84 && d < end3);
      e_blk[1] = d >= 80 && d < end3;
      e_blk[0] = d >= 84 && d < end3;
      e_hd = (d == end3);
      if (d >= 84 + f && d < 244 + f) begin e_ps = 1; e_px = d - 84 - f; end
    end else if (m_line < 153) begin
      e_mode = (m_line == 144 && d < 4) ? 0 : 1;
      e_ok = d >= 4;
      e_vb = (m_line == 144 && d == 4);
    end else begin
      e_mode = 1;
      if (d >= 4) e_line = 0;
      if (d < 4) e_ok = 0;
      else if (d < 8) e_cmp = 153;
      else if (d < 12) e_ok = 0;
      else e_cmp = 0;
    end
    if (!e_ok) e_cmp = 0;
  endtask

  task automatic compare();
    logic [3:0] a_blk;
    calc();
    a_blk = {spr_rd_blk, spr_wr_blk, vid_rd_blk, vid_wr_blk};
    check(int'(line_num) == e_line, tag("R1"), "line_num", int'(line_num), e_line);
    check(int'(mode) == e_mode, tag("R2"), "mode", int'(mode), e_mode);
    check(cmp_valid == e_ok && int'(cmp_line) == e_cmp, tag("R5"), "cmp {valid,line}",
          int'({cmp_valid, cmp_line}), int'({e_ok, e_cmp[7:0]}));
    check(a_blk == e_blk, tag("R4"), "blocks {sr,sw,vr,vw}", int'(a_blk), int'(e_blk));
    check(hblank_dma == e_hd, tag("R6"), "hblank_dma", int'(hblank_dma), int'(e_hd));
    check(vblank_irq == e_vb, tag("R9"), "vblank_irq", int'(vblank_irq), int'(e_vb));
    check(int'(pix_strobe) == e_ps && int'(pix_x) == e_px, tag("R7"), "pixel {strobe,x}",
          int'({pix_strobe, pix_x}), e_ps * 256 + e_px);

    // per-line and per-frame tallies
    if (m_on && m_dot == 0) begin cnt_strobe = 0; cnt_xfer = 0; end
    if (m_on && m_dot == 0 && m_line == 0) begin
      cnt_hd = 0; cnt_vb = 0; saw_first = m_first;
    end
    cnt_strobe += int'(pix_strobe);
    cnt_xfer   += int'(mode == 2'd3);
    cnt_hd     += int'(hblank_dma);
    cnt_vb     += int'(vblank_irq);
    if (m_on && !m_first && m_line < 144 && m_dot == 455) begin
      check(cnt_strobe == 160, "R7", "strobes in line", cnt_strobe, 160);
      check(cnt_xfer == 172 + m_fs, "R3", "transfer length", cnt_xfer, 172 + m_fs);
    end
    if (m_on && m_line == 153 && m_dot == 455) begin
      check(cnt_vb == 1, "R9", "vblank requests in frame", cnt_vb, 1);
      check(cnt_hd == (saw_first ? 143 : 144), "R6", "dma pulses in frame",
            cnt_hd, saw_first ? 143 : 144);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fine_scroll = lfsr[2:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) tick();
    rst_n = 1'b1;
    tick();
    check(line_num == 8'd0 && mode == 2'd0 && cmp_valid && !spr_rd_blk && !vid_wr_blk,
          "R11", "reset/off state", int'(mode), 0);
    repeat (10) tick();

    // full frame from enable, including the short opening line and wrap to line 0
    disp_en = 1'b1;
    repeat (70224 + 900) tick();

    // drop enable in the middle of a transfer, just before DMA would fire
    while (!(m_on && !m_first && m_line == 5 && m_dot == 200)) tick();
    disp_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      check(!hblank_dma && !spr_rd_blk && !spr_wr_blk && !vid_rd_blk && !vid_wr_blk &&
            line_num == 8'd0 && mode == 2'd0, "R11", "forced off state",
            int'({hblank_dma, spr_rd_blk, vid_rd_blk, mode}), 0);
    end

    // restart: first cycle is dot 0 of the opening line
    disp_en = 1'b1;
    tick();
    check(mode == 2'd0 && line_num == 8'd0 && !spr_rd_blk && !vid_rd_blk,
          "R12", "restart at dot 0", int'(mode), 0);
    repeat (75) tick();
    check(mode == 2'd0 && !spr_rd_blk, "R8", "opening idle through dot 75", int'(mode), 0);
    tick();
    check(mode == 2'd3 && spr_rd_blk && spr_wr_blk && vid_rd_blk && vid_wr_blk,
          "R12", "transfer begins at dot 76 after restart", int'(mode), 3);
    repeat (1500) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule